// File: doc/BRIEF.md
# Restart-Disabled Master Request Guard

This block sits in front of a two-wire serial bus master engine. Each master request arrives with a strobe and a set of descriptors. The descriptors say whether the direction changes inside the transfer, whether a START BYTE is wanted, whether high-speed mode is wanted, whether the transfer uses combined format, whether it is a read, and how many bytes it carries. The addressing mode comes from a static configuration input.

When the repeated-start capability is switched off, some operations cannot be carried out, and the guard refuses them. A refused request produces a one-cycle abort pulse and sets a sticky transmit-abort status bit. Software clears that bit with a clear strobe. A request that is accepted is passed to the bus engine one cycle later, with its descriptors registered. When repeated starts are enabled, every request is accepted.

Top module: `rsg_top`

## Requirements
- R1: While `restart_en` is 1, no request is refused: every `req_valid` produces `fwd_valid` one cycle later, with no `abort_pulse`.
- R2: While `restart_en` is 0, a request is refused if it has `dir_change`, `start_byte` or `hs_mode` set.
- R3: While `restart_en` is 0, a request with `combined` set is refused when `addr10` is 0 (7-bit addressing). With `addr10` equal to 1, `combined` on its own does not cause a refusal.
- R4: While `restart_en` is 0, a request with `is_read` set is refused when `addr10` is 1 (10-bit addressing).
- R5: While `restart_en` is 0, a request with `byte_cnt` greater than 1 is refused. A count of 0 or 1 is allowed.
- R6: `abort_pulse` is high for exactly the one cycle after the strobe of a refused request, and never at any other time.
- R7: A refused request sets `abort_sticky`, which is bit 6 of `raw_status`. Every other bit of `raw_status` is 0.
- R8: `abort_sticky` stays at 1 until `abort_clr` is pulsed. If a new abort occurs in the same cycle as the clear, the bit stays set.
- R9: A refused request is never forwarded. An accepted request raises `fwd_valid` for one cycle, with `fwd_read` and `fwd_cnt` equal to the request's values.
- R10: After reset, `abort_pulse`, `abort_sticky` and `fwd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_en | input | 1 | Repeated-start capability enable |
| addr10 | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit addressing |
| req_valid | input | 1 | Request strobe |
| dir_change | input | 1 | Direction changes inside the transfer |
| start_byte | input | 1 | START BYTE is requested |
| hs_mode | input | 1 | High-speed mode is requested |
| combined | input | 1 | Combined-format transfer |
| is_read | input | 1 | The transfer is a read |
| byte_cnt | input | CNT_W | Number of bytes in the transfer |
| abort_clr | input | 1 | Clears the sticky abort status |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_sticky | output | 1 | Sticky transmit-abort status |
| raw_status | output | STAT_W | Raw status word, with the abort in bit 6 |
| fwd_valid | output | 1 | Accepted request strobe to the bus engine |
| fwd_read | output | 1 | Forwarded read flag |
| fwd_cnt | output | CNT_W | Forwarded byte count |

## Verification
The assertions assume that `restart_en` and `addr10` are sampled only in the strobe cycle. They also assume that descriptors outside a strobe are don't-care. Because of this, the bench is free to toggle every input on every cycle. The stimulus draws each descriptor with its own probability so that single and combined violations both appear. It weights `byte_cnt` toward 0, 1 and 2 so that the count boundary is hit often. It also schedules clears that coincide with aborts, so the priority rule in R8 is exercised.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef struct packed {
    logic dir_change;
    logic start_byte;
    logic hs_mode;
    logic combined;
    logic is_read;
  } req_flags_t;
endpackage

// File: rtl/rsg_rule_eval.sv
module rsg_rule_eval
  import rsg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             restart_en,
  input  logic             addr10,
  input  req_flags_t       flags,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             forbid
);
  logic multi_byte;
  logic r_static, r_comb7, r_rd10;

  always_comb begin
    multi_byte = (byte_cnt > CNT_W'(1));
    r_static   = flags.dir_change | flags.start_byte | flags.hs_mode; // R2
    r_comb7    = flags.combined & ~addr10;                            // R3
    r_rd10     = flags.is_read & addr10;                              // R4
    forbid     = ~restart_en & (r_static | r_comb7 | r_rd10 | multi_byte); // R5, R1
  end
endmodule

// File: rtl/rsg_status.sv
module rsg_status #(
  parameter int STAT_W   = 32,
  parameter int ABRT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  output logic              sticky_o,
  output logic [STAT_W-1:0] status_o
);
  logic sticky_q, sticky_d, sticky_en;

  always_comb begin
    sticky_en = set_i | clr_i;
    sticky_d  = set_i;  // a set in the same cycle as a clear wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= 1'b0;
    else if (sticky_en) sticky_q <= sticky_d;
  end

  always_comb begin
    status_o           = '0;
    status_o[ABRT_BIT] = sticky_q;
    sticky_o           = sticky_q;
  end

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr_i) |=> sticky_q);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> sticky_q);
endmodule

// File: rtl/rsg_top.sv
module rsg_top
  import rsg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STAT_W   = 32,
  parameter int ABRT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_en,
  input  logic              addr10,
  input  logic              req_valid,
  input  logic              dir_change,
  input  logic              start_byte,
  input  logic              hs_mode,
  input  logic              combined,
  input  logic              is_read,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              abort_clr,
  output logic              abort_pulse,
  output logic              abort_sticky,
  output logic [STAT_W-1:0] raw_status,
  output logic              fwd_valid,
  output logic              fwd_read,
  output logic [CNT_W-1:0]  fwd_cnt
);
  req_flags_t       flags;
  logic             forbid;
  logic             abort_d, abort_q;
  logic             fv_d, fv_q;
  logic             fr_q;
  logic [CNT_W-1:0] fc_q;
  logic             data_en;

  always_comb begin
    flags.dir_change = dir_change;
    flags.start_byte = start_byte;
    flags.hs_mode    = hs_mode;
    flags.combined   = combined;
    flags.is_read    = is_read;
  end

  rsg_rule_eval #(.CNT_W(CNT_W)) u_eval (
    .restart_en (restart_en),
    .addr10     (addr10),
    .flags      (flags),
    .byte_cnt   (byte_cnt),
    .forbid     (forbid)
  );

  always_comb begin
    abort_d = req_valid & forbid;
    fv_d    = req_valid & ~forbid;
    data_en = fv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      fv_q    <= 1'b0;
    end else begin
      abort_q <= abort_d;
      fv_q    <= fv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0;
      fc_q <= '0;
    end else if (data_en) begin
      fr_q <= is_read;
      fc_q <= byte_cnt;
    end
  end

  rsg_status #(.STAT_W(STAT_W), .ABRT_BIT(ABRT_BIT)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (abort_d),
    .clr_i    (abort_clr),
    .sticky_o (abort_sticky),
    .status_o (raw_status)
  );

  always_comb begin
    abort_pulse = abort_q;
    fwd_valid   = fv_q;
    fwd_read    = fr_q;
    fwd_cnt     = fc_q;
  end

  assert_no_abort_when_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && restart_en) |=> (fwd_valid && !abort_pulse));
  assert_hs_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !restart_en && hs_mode) |=> abort_pulse);
  assert_multi_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !restart_en && byte_cnt > CNT_W'(1)) |=> abort_pulse);
  assert_pulse_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !abort_pulse);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_pulse && fwd_valid));
  assert_status_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(raw_status) <= 1);
endmodule

// File: tb/rsg_top_bench.sv
module rsg_top_bench;
  localparam int CNT_W = 8;
  localparam int STAT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_en = 1'b0, addr10 = 1'b0, req_valid = 1'b0;
  logic dir_change = 1'b0, start_byte = 1'b0, hs_mode = 1'b0, combined = 1'b0, is_read = 1'b0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic abort_clr = 1'b0;
  logic abort_pulse, abort_sticky, fwd_valid, fwd_read;
  logic [STAT_W-1:0] raw_status;
  logic [CNT_W-1:0] fwd_cnt;

  int n_chk = 0, n_bad = 0;
  logic exp_sticky = 1'b0;

  always #4 clk = ~clk;

  rsg_top u_rsg_top (.*);

  function automatic logic exp_forbid(logic re, logic a10, logic dc, logic sb, logic hs,
                                      logic cb, logic rd, logic [CNT_W-1:0] n);
    if (re) return 1'b0;
    return dc | sb | hs | (cb & ~a10) | (rd & a10) | (n > 1);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle then check outputs after the edge
  task automatic step(logic rv, logic re, logic a10, logic dc, logic sb, logic hs,
                      logic cb, logic rd, logic [CNT_W-1:0] n, logic clr, string tag);
    logic f;
    restart_en = re; addr10 = a10; req_valid = rv; dir_change = dc; start_byte = sb;
    hs_mode = hs; combined = cb; is_read = rd; byte_cnt = n; abort_clr = clr;
    f = exp_forbid(re, a10, dc, sb, hs, cb, rd, n);
    @(posedge clk); #1;
    if (rv && f) exp_sticky = 1'b1;
    else if (clr) exp_sticky = 1'b0;
    check({tag, " R6 pulse"}, 64'(abort_pulse), 64'(rv && f));
    check({tag, " R9 fwd"}, 64'(fwd_valid), 64'(rv && !f));
    if (rv && !f) begin
      check({tag, " R9 read"}, 64'(fwd_read), 64'(rd));
      check({tag, " R9 cnt"}, 64'(fwd_cnt), 64'(n));
    end
    check({tag, " R8 sticky"}, 64'(abort_sticky), 64'(exp_sticky));
    check({tag, " R7 status"}, raw_status, 64'(exp_sticky) << 6);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] n;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R10 pulse", 64'(abort_pulse), 0);
    check("R10 sticky", 64'(abort_sticky), 0);
    check("R10 fwd", 64'(fwd_valid), 0);
    rst_n = 1'b1;
    // directed corner cases
    step(1,1,0,1,1,1,1,0,8'd5,0,"R1 all-set enabled");
    step(1,0,0,1,0,0,0,0,8'd1,0,"R2 dirchg");
    step(1,0,0,0,0,0,0,0,8'd1,1,"R8 clr");
    step(1,0,0,0,1,0,0,0,8'd1,1,"R2 startbyte+clr wins");
    step(1,0,0,0,0,1,0,0,8'd0,1,"R2 hs+clr");
    step(0,0,0,0,0,0,0,0,8'd0,1,"R8 clear");
    step(1,0,0,0,0,0,1,0,8'd1,0,"R3 comb7");
    step(0,0,0,0,0,0,0,0,8'd0,1,"R8 clear2");
    step(1,0,1,0,0,0,1,0,8'd1,0,"R3 comb10 ok");
    step(1,0,1,0,0,0,0,1,8'd1,0,"R4 rd10");
    step(1,0,0,0,0,0,0,1,8'd1,1,"R4 rd7 ok");
    step(1,0,0,0,0,0,0,0,8'd2,0,"R5 cnt2");
    step(1,0,0,0,0,0,0,0,8'd0,1,"R5 cnt0 ok");
    step(1,0,0,0,0,0,0,1,8'd1,0,"R5 cnt1 ok");
    step(0,0,0,1,1,1,1,1,8'd9,0,"R6 no strobe");
    // random
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      n = (k < 3) ? 8'(k) : 8'($urandom_range(0, 255));
      step($urandom_range(0,3) != 0, $urandom_range(0,3) == 0, 1'($urandom),
           $urandom_range(0,5) == 0, $urandom_range(0,7) == 0, $urandom_range(0,7) == 0,
           $urandom_range(0,3) == 0, 1'($urandom), n, $urandom_range(0,4) == 0, "rand");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule